// File: doc/BRIEF.md
# TLB Refill Exception Dispatch

This block turns a translation-miss report from the memory pipeline into a complete exception entry. In the cycle after a miss is reported, it drives the redirect PC for the handler. It also pulses write strobes, with data, for the fault-address capture registers, the page-table pointer registers, the exception PC, the Cause fields and the Status exception-level bit. The TLB array, the table walk and the handler software lie outside this block.

Handler selection depends on the region the faulting address lives in, not on the mode the processor runs in:

- The address is sorted into user, supervisor or kernel space.
- That space's extended-addressing enable picks the 64-bit refill entry when set and the 32-bit entry when clear.
- If the core is already at exception level, the miss goes instead to the common vector, and the saved return state is left alone.

Addresses in the unmapped windows can never miss, so a report there produces nothing.

Top module: `tlb_refill_dispatch`

## Requirements
- R1: A miss report (`missValid` high at a rising edge) on a mapped address raises `redirectValid`, `causeWe` and `exlSet` for exactly one cycle, with outputs visible after the next rising edge. No enable masks this.
- R2: Addresses are classified as follows:
  - The sign-extended 32-bit range 0xFFFFFFFF_C0000000–0xFFFFFFFF_DFFFFFFF is supervisor space.
  - 0xFFFFFFFF_E0000000 and above is kernel space.
  - Every other address is classified by bits [63:62]: 00 is user, 01 is supervisor and 11 is kernel.
- R3: With `statusExl` clear, `redirectPc` is 0xFFFFFFFF_80000000 when the enable for the classified space (`statusUx`, `statusSx` or `statusKx`) is 0, and 0xFFFFFFFF_80000080 when it is 1. The enables of the other spaces have no effect.
- R4: A report whose address is in an unmapped window produces no strobe at all. The unmapped windows are 0xFFFFFFFF_80000000–0xFFFFFFFF_BFFFFFFF and any address with bits [63:62] = 10.
- R5: With `statusExl` set, `redirectPc` is 0xFFFFFFFF_80000180 and `epcWe` stays low. The address-capture strobes and `causeWe` still pulse.
- R6: `excCode` is 2 for a fetch (`accType` 0) or a load (`accType` 1), and 3 for a store (`accType` 2).
- R7: `badVAddr` equals the faulting address. `entryHiData` is {VA[63:13], zero padding, `asid`}, with `asid` in the low ASID_W bits.
- R8: `contextData` is `contextIn` with bits [22:4] replaced by VA[31:13]. `xcontextData` is `xcontextIn` with bits [34:4] replaced by VA[43:13] and bits [36:35] replaced by VA[63:62]. All other bits pass through.
- R9: When `epcWe` pulses, `epcData` is `pc` and `bdData` is 0. If `inDelaySlot` is set, `epcData` is `pc` − 4 and `bdData` is 1.
- R10: After reset every strobe output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss report valid |
| va | input | 64 | Faulting virtual address |
| accType | input | 2 | 0 fetch, 1 load, 2 store |
| asid | input | ASID_W | Current address-space ID |
| pc | input | 64 | Faulting instruction address |
| inDelaySlot | input | 1 | Instruction sits in a branch delay slot |
| statusExl | input | 1 | Current exception level |
| statusUx | input | 1 | User space extended addressing |
| statusSx | input | 1 | Supervisor space extended addressing |
| statusKx | input | 1 | Kernel space extended addressing |
| contextIn | input | 64 | Current Context register |
| xcontextIn | input | 64 | Current XContext register |
| redirectValid | output | 1 | Fetch redirect strobe |
| redirectPc | output | 64 | Handler address |
| badVAddrWe | output | 1 | BadVAddr write strobe |
| badVAddr | output | 64 | BadVAddr data |
| contextWe | output | 1 | Context write strobe |
| contextData | output | 64 | Context data |
| xcontextWe | output | 1 | XContext write strobe |
| xcontextData | output | 64 | XContext data |
| entryHiWe | output | 1 | EntryHi write strobe |
| entryHiData | output | 64 | EntryHi data |
| epcWe | output | 1 | EPC and Cause.BD write strobe |
| epcData | output | 64 | EPC data |
| bdData | output | 1 | Cause.BD data |
| causeWe | output | 1 | Cause.ExcCode write strobe |
| excCode | output | 5 | ExcCode data |
| exlSet | output | 1 | Set Status exception level |

## Verification
The bench aims at the classification boundaries, with one enable set and the others clear.

- **Supervisor space in the upper compatibility window.** A design that read only bits [63:62] would treat it as kernel and follow `statusKx`.
- **Unmapped windows.** A design that forgot them would raise a refill on an address that cannot miss.
- **Nested miss.** A wrong design would jump to a refill vector, or overwrite EPC and lose the original return point.
- **Delay-slot miss.** A wrong design would return past the branch.
- **Non-zero page-table bases.** A wrong design would corrupt the base bits instead of merging only the page-number fields.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    SPACE_USER     = 2'd0,
    SPACE_SUPER    = 2'd1,
    SPACE_KERNEL   = 2'd2,
    SPACE_UNMAPPED = 2'd3
  } space_t;

  localparam logic [1:0] ACC_STORE = 2'd2;
  localparam logic [4:0] CODE_MISS_LOAD  = 5'd2;
  localparam logic [4:0] CODE_MISS_STORE = 5'd3;

  typedef struct packed {
    logic fire;
    logic nested;
    logic useWideVec;
    logic isStore;
  } refill_strobe_t;
endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic           missValid,
  input  logic [63:0]    va,
  input  logic [1:0]     accType,
  input  logic           statusExl,
  input  logic           statusUx,
  input  logic           statusSx,
  input  logic           statusKx,
  output refill_strobe_t strb
);
  space_t space;
  logic   compatNeg;
  logic   wideBit;

  // Upper half of the sign-extended 32-bit range.
  assign compatNeg = &va[63:31];

  always_comb begin
    if (compatNeg) begin
      unique case (va[30:29])
        2'b10:   space = SPACE_SUPER;
        2'b11:   space = SPACE_KERNEL;
        default: space = SPACE_UNMAPPED;
      endcase
    end else begin
      unique case (va[63:62])
        2'b00:   space = SPACE_USER;
        2'b01:   space = SPACE_SUPER;
        2'b11:   space = SPACE_KERNEL;
        default: space = SPACE_UNMAPPED;
      endcase
    end
  end

  always_comb begin
    unique case (space)
      SPACE_USER:   wideBit = statusUx;
      SPACE_SUPER:  wideBit = statusSx;
      SPACE_KERNEL: wideBit = statusKx;
      default:      wideBit = 1'b0;
    endcase
  end

  always_comb begin
    strb.fire       = missValid && (space != SPACE_UNMAPPED);
    strb.nested     = statusExl;
    strb.useWideVec = wideBit;
    strb.isStore    = (accType == ACC_STORE);
  end
endmodule

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int          ASID_W      = 8,
  parameter logic [63:0] VECTOR_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter logic [63:0] OFF_NARROW  = 64'h000,
  parameter logic [63:0] OFF_WIDE    = 64'h080,
  parameter logic [63:0] OFF_COMMON  = 64'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  refill_strobe_t    strb,
  input  logic [63:0]       va,
  input  logic [ASID_W-1:0] asid,
  input  logic [63:0]       pc,
  input  logic              inDelaySlot,
  input  logic [63:0]       contextIn,
  input  logic [63:0]       xcontextIn,
  output logic              redirectValid,
  output logic [63:0]       redirectPc,
  output logic              badVAddrWe,
  output logic [63:0]       badVAddr,
  output logic              contextWe,
  output logic [63:0]       contextData,
  output logic              xcontextWe,
  output logic [63:0]       xcontextData,
  output logic              entryHiWe,
  output logic [63:0]       entryHiData,
  output logic              epcWe,
  output logic [63:0]       epcData,
  output logic              bdData,
  output logic              causeWe,
  output logic [4:0]        excCode,
  output logic              exlSet
);
  localparam int HI_PAD = 13 - ASID_W;

  logic [63:0] vecNext;
  assign vecNext = VECTOR_BASE +
                   (strb.nested ? OFF_COMMON : (strb.useWideVec ? OFF_WIDE : OFF_NARROW));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      badVAddrWe    <= 1'b0;
      badVAddr      <= '0;
      contextWe     <= 1'b0;
      contextData   <= '0;
      xcontextWe    <= 1'b0;
      xcontextData  <= '0;
      entryHiWe     <= 1'b0;
      entryHiData   <= '0;
      epcWe         <= 1'b0;
      epcData       <= '0;
      bdData        <= 1'b0;
      causeWe       <= 1'b0;
      excCode       <= '0;
      exlSet        <= 1'b0;
    end else begin
      redirectValid <= 1'b0;
      badVAddrWe    <= 1'b0;
      contextWe     <= 1'b0;
      xcontextWe    <= 1'b0;
      entryHiWe     <= 1'b0;
      epcWe         <= 1'b0;
      causeWe       <= 1'b0;
      exlSet        <= 1'b0;
      if (strb.fire) begin
        redirectValid <= 1'b1;
        redirectPc    <= vecNext;
        badVAddrWe    <= 1'b1;
        badVAddr      <= va;
        contextWe     <= 1'b1;
        contextData   <= {contextIn[63:23], va[31:13], contextIn[3:0]};
        xcontextWe    <= 1'b1;
        xcontextData  <= {xcontextIn[63:37], va[63:62], va[43:13], xcontextIn[3:0]};
        entryHiWe     <= 1'b1;
        entryHiData   <= {va[63:13], {HI_PAD{1'b0}}, asid};
        causeWe       <= 1'b1;
        excCode       <= strb.isStore ? CODE_MISS_STORE : CODE_MISS_LOAD;
        exlSet        <= 1'b1;
        // A nested miss keeps the original return point.
        if (!strb.nested) begin
          epcWe   <= 1'b1;
          epcData <= inDelaySlot ? pc - 64'd4 : pc;
          bdData  <= inDelaySlot;
        end
      end
    end
  end

  assert_fire_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> (redirectValid && causeWe && exlSet && badVAddr == $past(va)));

  assert_vector_common_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.nested) |=> (redirectPc == VECTOR_BASE + OFF_COMMON && !epcWe));

  assert_epc_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && !strb.nested && inDelaySlot) |=> (epcData == $past(pc) - 64'd4 && bdData));

  assert_store_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fire && strb.isStore) |=> (excCode == CODE_MISS_STORE));
endmodule

// File: rtl/tlb_refill_dispatch.sv
module tlb_refill_dispatch
  import refill_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [63:0]       va,
  input  logic [1:0]        accType,
  input  logic [ASID_W-1:0] asid,
  input  logic [63:0]       pc,
  input  logic              inDelaySlot,
  input  logic              statusExl,
  input  logic              statusUx,
  input  logic              statusSx,
  input  logic              statusKx,
  input  logic [63:0]       contextIn,
  input  logic [63:0]       xcontextIn,
  output logic              redirectValid,
  output logic [63:0]       redirectPc,
  output logic              badVAddrWe,
  output logic [63:0]       badVAddr,
  output logic              contextWe,
  output logic [63:0]       contextData,
  output logic              xcontextWe,
  output logic [63:0]       xcontextData,
  output logic              entryHiWe,
  output logic [63:0]       entryHiData,
  output logic              epcWe,
  output logic [63:0]       epcData,
  output logic              bdData,
  output logic              causeWe,
  output logic [4:0]        excCode,
  output logic              exlSet
);
  refill_strobe_t strb;

  refill_ctrl ctrl (
    .missValid (missValid),
    .va        (va),
    .accType   (accType),
    .statusExl (statusExl),
    .statusUx  (statusUx),
    .statusSx  (statusSx),
    .statusKx  (statusKx),
    .strb      (strb)
  );

  refill_datapath #(.ASID_W(ASID_W)) dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .va            (va),
    .asid          (asid),
    .pc            (pc),
    .inDelaySlot   (inDelaySlot),
    .contextIn     (contextIn),
    .xcontextIn    (xcontextIn),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .badVAddrWe    (badVAddrWe),
    .badVAddr      (badVAddr),
    .contextWe     (contextWe),
    .contextData   (contextData),
    .xcontextWe    (xcontextWe),
    .xcontextData  (xcontextData),
    .entryHiWe     (entryHiWe),
    .entryHiData   (entryHiData),
    .epcWe         (epcWe),
    .epcData       (epcData),
    .bdData        (bdData),
    .causeWe       (causeWe),
    .excCode       (excCode),
    .exlSet        (exlSet)
  );

  assert_unmapped_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && (va[63:62] == 2'b10 || va[63:30] == {33'h1_FFFF_FFFF, 1'b0}))
      |=> (!redirectValid && !badVAddrWe && !causeWe));
endmodule

// File: tb/tlb_refill_dispatch_test.sv
`timescale 1ns/1ps
module tlb_refill_dispatch_test;
  localparam logic [63:0] BASE = 64'hFFFF_FFFF_8000_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        missValid;
  logic [63:0] va;
  logic [1:0]  accType;
  logic [7:0]  asid;
  logic [63:0] pc;
  logic        inDelaySlot, statusExl, statusUx, statusSx, statusKx;
  logic [63:0] contextIn, xcontextIn;
  logic        redirectValid, badVAddrWe, contextWe, xcontextWe, entryHiWe;
  logic        epcWe, bdData, causeWe, exlSet;
  logic [63:0] redirectPc, badVAddr, contextData, xcontextData, entryHiData, epcData;
  logic [4:0]  excCode;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tlb_refill_dispatch uut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .va(va), .accType(accType),
    .asid(asid), .pc(pc), .inDelaySlot(inDelaySlot), .statusExl(statusExl),
    .statusUx(statusUx), .statusSx(statusSx), .statusKx(statusKx),
    .contextIn(contextIn), .xcontextIn(xcontextIn),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .badVAddrWe(badVAddrWe), .badVAddr(badVAddr), .contextWe(contextWe),
    .contextData(contextData), .xcontextWe(xcontextWe), .xcontextData(xcontextData),
    .entryHiWe(entryHiWe), .entryHiData(entryHiData), .epcWe(epcWe),
    .epcData(epcData), .bdData(bdData), .causeWe(causeWe), .excCode(excCode),
    .exlSet(exlSet)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one report at a falling edge; outputs are sampled one cycle later.
  task automatic doMiss(input logic [63:0] a, input logic [1:0] t, input logic exl,
                        input logic ux, input logic sx, input logic kx);
    @(negedge clk);
    va = a; accType = t; statusExl = exl;
    statusUx = ux; statusSx = sx; statusKx = kx;
    missValid = 1'b1;
    @(negedge clk);
    missValid = 1'b0;
  endtask

  task automatic testReset();
    check("R10 redirectValid", {63'd0, redirectValid}, 64'd0);
    check("R10 strobes", {56'd0, badVAddrWe, contextWe, xcontextWe, entryHiWe,
                          epcWe, causeWe, exlSet, 1'b0}, 64'd0);
  endtask

  task automatic testUser();
    doMiss(64'h0000_0000_0040_2000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R1 redirect pulse", {63'd0, redirectValid}, 64'd1);
    check("R3 user narrow", redirectPc, BASE);
    check("R6 fetch code", {59'd0, excCode}, 64'd2);
    check("R1 exlSet", {63'd0, exlSet}, 64'd1);
    @(negedge clk);
    check("R1 single cycle", {63'd0, redirectValid}, 64'd0);
    doMiss(64'h0000_0000_0040_2000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R3 user wide", redirectPc, BASE + 64'h80);
    check("R6 load code", {59'd0, excCode}, 64'd2);
  endtask

  task automatic testSuper();
    doMiss(64'hFFFF_FFFF_C000_1000, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 compat super wide", redirectPc, BASE + 64'h80);
    check("R6 store code", {59'd0, excCode}, 64'd3);
    doMiss(64'hFFFF_FFFF_C000_1000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R2 compat super narrow", redirectPc, BASE);
    doMiss(64'h4000_0000_1234_0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 xsuper wide", redirectPc, BASE + 64'h80);
  endtask

  task automatic testKernel();
    doMiss(64'hFFFF_FFFF_E000_4000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R2 compat kernel narrow", redirectPc, BASE);
    doMiss(64'hFFFF_FFFF_E000_4000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 compat kernel wide", redirectPc, BASE + 64'h80);
    doMiss(64'hC000_0000_0000_8000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 xkernel wide", redirectPc, BASE + 64'h80);
  endtask

  task automatic testUnmapped();
    doMiss(64'hFFFF_FFFF_8000_1000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R4 compat unmapped redirect", {63'd0, redirectValid}, 64'd0);
    check("R4 compat unmapped capture", {62'd0, badVAddrWe, causeWe}, 64'd0);
    doMiss(64'hFFFF_FFFF_BFFF_F000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R4 compat unmapped top", {63'd0, redirectValid}, 64'd0);
    doMiss(64'h8000_0000_0000_1000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R4 phys window", {61'd0, redirectValid, epcWe, exlSet}, 64'd0);
  endtask

  task automatic testNested();
    pc = 64'h0000_0000_0040_0100; inDelaySlot = 1'b0;
    doMiss(64'h0000_0000_0010_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 epc plain", epcData, 64'h0000_0000_0040_0100);
    check("R9 bd plain", {63'd0, bdData}, 64'd0);
    pc = 64'h0000_0000_0077_0000; inDelaySlot = 1'b1;
    doMiss(64'h0000_0000_0020_0000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R5 common vector", redirectPc, BASE + 64'h180);
    check("R5 no epc write", {63'd0, epcWe}, 64'd0);
    check("R5 capture still", {62'd0, badVAddrWe, causeWe}, 64'd3);
    check("R5 badvaddr", badVAddr, 64'h0000_0000_0020_0000);
    check("R5 epc held", epcData, 64'h0000_0000_0040_0100);
  endtask

  task automatic testDelaySlot();
    pc = 64'h0000_0000_0040_0204; inDelaySlot = 1'b1;
    doMiss(64'h0000_0000_0010_0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 epc write", {63'd0, epcWe}, 64'd1);
    check("R9 epc branch", epcData, 64'h0000_0000_0040_0200);
    check("R9 bd set", {63'd0, bdData}, 64'd1);
    inDelaySlot = 1'b0;
  endtask

  task automatic testCapture();
    logic [63:0] a;
    a = 64'h4123_4567_89AB_E000;
    asid = 8'h5A;
    contextIn  = 64'hFFFF_FFFF_FFFF_FFFF;
    xcontextIn = 64'hAAAA_AAAA_AAAA_AAAA;
    doMiss(a, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 badvaddr", badVAddr, a);
    check("R7 entryhi", entryHiData, {a[63:13], 5'd0, 8'h5A});
    check("R8 context", contextData, {contextIn[63:23], a[31:13], contextIn[3:0]});
    check("R8 xcontext", xcontextData,
          {xcontextIn[63:37], a[63:62], a[43:13], xcontextIn[3:0]});
    check("R8 strobes", {61'd0, contextWe, xcontextWe, entryHiWe}, 64'd7);
  endtask

  initial begin
    rstN = 1'b0; missValid = 1'b0; va = '0; accType = '0; asid = '0; pc = '0;
    inDelaySlot = 1'b0; statusExl = 1'b0; statusUx = 1'b0; statusSx = 1'b0;
    statusKx = 1'b0; contextIn = '0; xcontextIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUser();
    testSuper();
    testKernel();
    testUnmapped();
    testNested();
    testDelaySlot();
    testCapture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule